// File: doc/BRIEF.md
# Self-Routing Omega Interconnect

This block is an N-port multistage switching fabric that carries fixed-width messages from source ports to destination ports. It is built from log2(N) columns of two-by-two switching elements, N/2 of them per column, with a perfect-shuffle link pattern before each column. Every element sets itself from one bit of the destination index carried by each message. No central controller and no routing table are involved.

Each source offers a valid flag, a destination index, a broadcast flag and a payload. Inputs are captured in one register rank. The columns of elements are pure logic. The results land in a second register rank, so every result is seen one clock after capture. A message that loses an internal link conflict is dropped, and its source is marked in a per-source blocked vector. A source that is the only active one in a cycle may ask for broadcast. The elements on its tree then copy it to both of their outputs, and it reaches every output port. A broadcast request that shares its cycle with any other active source is refused and flagged.

Top module: `omega_fabric`

## Requirements
- R1: While rst_ni is low, and after it rises until a message arrives, every bit of out_valid_o and blocked_o is 0.
- R2: A lone non-broadcast message from source s, whose fields sit at in_dest_i[s*LOG_N +: LOG_N] and in_data_i[s*DATA_W +: DATA_W], is presented before clock edge E. After edge E+1 it appears on output port d = its destination, with out_src_o[d*LOG_N +: LOG_N] = s and an unchanged payload, and blocked_o is all 0.
- R3: The route of each message is traced from position p = s. Before column k, p is rotated left by one bit within LOG_N bits. The element is p/2, the input is upper when p is even, and the new p is (p with its lowest bit replaced by destination bit LOG_N-1-k). When two messages want the same new p, the one on the upper input continues. The other is dropped, and blocked_o[its source] is 1 in the same cycle that the outputs appear.
- R4: Permutations that cause no collision under R3, such as the identity and every cyclic shift of destinations, deliver all N messages and flag none.
- R5: A message with in_bcast_i set, presented while it is the only valid source, appears on all N output ports with its own source index and payload, and it is not flagged.
- R6: A broadcast request made while any other source is valid is flagged in blocked_o and reaches no output. The other, non-broadcast messages in that cycle are routed as if the refused request were absent.
- R7: A source that was not valid is never flagged, and an output port that no message reaches shows out_valid_o = 0. Every valid source without a legal broadcast is either delivered exactly once or flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_PORTS | Message present, one bit per source |
| in_bcast_i | input | N_PORTS | Broadcast request, one bit per source |
| in_dest_i | input | N_PORTS*LOG_N | Destination index, field s for source s |
| in_data_i | input | N_PORTS*DATA_W | Payload, field s for source s |
| out_valid_o | output | N_PORTS | Message delivered, one bit per output port |
| out_src_o | output | N_PORTS*LOG_N | Source index of the delivered message, per output port |
| out_data_o | output | N_PORTS*DATA_W | Delivered payload, per output port |
| blocked_o | output | N_PORTS | Source message dropped, one bit per source |

## Verification
Every result of this block, whether the delivered port contents or the blocked vector, is due two rising edges after the negative edge at which its inputs are driven. One edge loads the input rank and the next loads the output rank. The reference model in the bench keeps a two-entry queue of predictions and compares the outputs on every falling edge against the prediction made two falling edges earlier. Back-to-back vectors, conflicts and broadcasts therefore never share a sample. The checker keeps its own two-deep history of the input valid and broadcast bits for the same reason.

// File: rtl/omega_pkg.sv
package omega_pkg;

  typedef enum logic [1:0] {
    SW_PASS  = 2'd0,
    SW_CROSS = 2'd1,
    SW_BC_UP = 2'd2,
    SW_BC_LO = 2'd3
  } sw_mode_e;

  // perfect shuffle: rotate a lg-bit port index left by one
  function automatic int unsigned shuffle_idx(input int unsigned p, input int unsigned lg);
    int unsigned n;
    n = 32'd1 << lg;
    return ((p << 1) | (p >> (lg - 1))) & (n - 1);
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch
  import omega_pkg::*;
#(
  parameter int LOG_N  = 3,
  parameter int DATA_W = 16,
  parameter int DBIT   = 0
) (
  input  logic [1:0]             v_i,
  input  logic [1:0]             b_i,
  input  logic [1:0][LOG_N-1:0]  src_i,
  input  logic [1:0][LOG_N-1:0]  dst_i,
  input  logic [1:0][DATA_W-1:0] dat_i,
  output logic [1:0]             v_o,
  output logic [1:0]             b_o,
  output logic [1:0][LOG_N-1:0]  src_o,
  output logic [1:0][LOG_N-1:0]  dst_o,
  output logic [1:0][DATA_W-1:0] dat_o,
  output logic                   lose_o
);

  sw_mode_e   mode;
  logic       up_bit, lo_bit;
  logic [1:0] v_m;
  logic [1:0] sel;

  assign up_bit = dst_i[0][DBIT];
  assign lo_bit = dst_i[1][DBIT];

  // upper input has priority on a shared output
  always_comb begin
    mode   = SW_PASS;
    lose_o = 1'b0;
    if (v_i[0] && b_i[0]) begin
      mode = SW_BC_UP;
    end else if (v_i[1] && b_i[1]) begin
      mode = SW_BC_LO;
    end else if (v_i[0]) begin
      mode   = up_bit ? SW_CROSS : SW_PASS;
      lose_o = v_i[1] && (lo_bit == up_bit);
    end else if (v_i[1]) begin
      mode = lo_bit ? SW_PASS : SW_CROSS;
    end
  end

  assign v_m = {v_i[1] & ~lose_o, v_i[0]};

  always_comb begin
    unique case (mode)
      SW_PASS:  sel = 2'b10;
      SW_CROSS: sel = 2'b01;
      SW_BC_UP: sel = 2'b00;
      SW_BC_LO: sel = 2'b11;
      default:  sel = 2'b10;
    endcase
  end

  always_comb begin
    for (int j = 0; j < 2; j++) begin
      v_o[j]   = v_m[sel[j]];
      b_o[j]   = b_i[sel[j]];
      src_o[j] = src_i[sel[j]];
      dst_o[j] = dst_i[sel[j]];
      dat_o[j] = dat_i[sel[j]];
    end
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
  import omega_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int LOG_N   = 3,
  parameter int DATA_W  = 16,
  parameter int STAGE   = 0
) (
  input  logic [N_PORTS-1:0]             v_i,
  input  logic [N_PORTS-1:0]             b_i,
  input  logic [N_PORTS-1:0][LOG_N-1:0]  src_i,
  input  logic [N_PORTS-1:0][LOG_N-1:0]  dst_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] dat_i,
  output logic [N_PORTS-1:0]             v_o,
  output logic [N_PORTS-1:0]             b_o,
  output logic [N_PORTS-1:0][LOG_N-1:0]  src_o,
  output logic [N_PORTS-1:0][LOG_N-1:0]  dst_o,
  output logic [N_PORTS-1:0][DATA_W-1:0] dat_o,
  output logic [N_PORTS-1:0]             blk_o
);

  localparam int HALF = N_PORTS / 2;
  localparam int DBIT = LOG_N - 1 - STAGE;

  logic [N_PORTS-1:0]             v_sh, b_sh;
  logic [N_PORTS-1:0][LOG_N-1:0]  src_sh, dst_sh;
  logic [N_PORTS-1:0][DATA_W-1:0] dat_sh;
  logic [HALF-1:0]                lose;

  always_comb begin
    v_sh   = '0;
    b_sh   = '0;
    src_sh = '0;
    dst_sh = '0;
    dat_sh = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      v_sh[shuffle_idx(p, LOG_N)]   = v_i[p];
      b_sh[shuffle_idx(p, LOG_N)]   = b_i[p];
      src_sh[shuffle_idx(p, LOG_N)] = src_i[p];
      dst_sh[shuffle_idx(p, LOG_N)] = dst_i[p];
      dat_sh[shuffle_idx(p, LOG_N)] = dat_i[p];
    end
  end

  for (genvar e = 0; e < HALF; e++) begin : g_sw
    omega_switch #(
      .LOG_N (LOG_N),
      .DATA_W(DATA_W),
      .DBIT  (DBIT)
    ) u_sw (
      .v_i   (v_sh[2*e +: 2]),
      .b_i   (b_sh[2*e +: 2]),
      .src_i (src_sh[2*e +: 2]),
      .dst_i (dst_sh[2*e +: 2]),
      .dat_i (dat_sh[2*e +: 2]),
      .v_o   (v_o[2*e +: 2]),
      .b_o   (b_o[2*e +: 2]),
      .src_o (src_o[2*e +: 2]),
      .dst_o (dst_o[2*e +: 2]),
      .dat_o (dat_o[2*e +: 2]),
      .lose_o(lose[e])
    );
  end

  // loser always sits on the lower input
  always_comb begin
    blk_o = '0;
    for (int e = 0; e < HALF; e++) begin
      if (lose[e]) blk_o[src_sh[2*e+1]] = 1'b1;
    end
  end

endmodule

// File: rtl/omega_ingress.sv
module omega_ingress #(
  parameter int N_PORTS = 8
) (
  input  logic [N_PORTS-1:0] v_i,
  input  logic [N_PORTS-1:0] b_i,
  output logic [N_PORTS-1:0] v_o,
  output logic [N_PORTS-1:0] b_o,
  output logic [N_PORTS-1:0] blk_o
);

  logic solo;
  logic [N_PORTS-1:0] bc_req;

  assign solo   = ($countones(v_i) == 1);
  assign bc_req = v_i & b_i;
  assign blk_o  = solo ? '0 : bc_req;
  assign v_o    = v_i & ~blk_o;
  assign b_o    = solo ? bc_req : '0;

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 16,
  parameter int LOG_N   = $clog2(N_PORTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PORTS-1:0]          in_valid_i,
  input  logic [N_PORTS-1:0]          in_bcast_i,
  input  logic [N_PORTS*LOG_N-1:0]    in_dest_i,
  input  logic [N_PORTS*DATA_W-1:0]   in_data_i,
  output logic [N_PORTS-1:0]          out_valid_o,
  output logic [N_PORTS*LOG_N-1:0]    out_src_o,
  output logic [N_PORTS*DATA_W-1:0]   out_data_o,
  output logic [N_PORTS-1:0]          blocked_o
);

  logic [N_PORTS-1:0]             in_v_q, in_b_q;
  logic [N_PORTS-1:0][LOG_N-1:0]  in_d_q;
  logic [N_PORTS-1:0][DATA_W-1:0] in_x_q;

  logic [LOG_N:0][N_PORTS-1:0]             v_s, b_s;
  logic [LOG_N:0][N_PORTS-1:0][LOG_N-1:0]  s_s, d_s;
  logic [LOG_N:0][N_PORTS-1:0][DATA_W-1:0] x_s;
  logic [LOG_N-1:0][N_PORTS-1:0]           blk_s;
  logic [N_PORTS-1:0]                      ing_blk, blk_all;

  logic [N_PORTS-1:0]             out_v_q, blk_q;
  logic [N_PORTS-1:0][LOG_N-1:0]  out_s_q;
  logic [N_PORTS-1:0][DATA_W-1:0] out_x_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_v_q <= '0;
      in_b_q <= '0;
      in_d_q <= '0;
      in_x_q <= '0;
    end else begin
      in_v_q <= in_valid_i;
      in_b_q <= in_bcast_i;
      in_d_q <= in_dest_i;
      in_x_q <= in_data_i;
    end
  end

  omega_ingress #(.N_PORTS(N_PORTS)) u_ingress (
    .v_i  (in_v_q),
    .b_i  (in_b_q),
    .v_o  (v_s[0]),
    .b_o  (b_s[0]),
    .blk_o(ing_blk)
  );

  always_comb begin
    for (int p = 0; p < N_PORTS; p++) s_s[0][p] = LOG_N'(p);
  end
  assign d_s[0] = in_d_q;
  assign x_s[0] = in_x_q;

  for (genvar k = 0; k < LOG_N; k++) begin : g_stage
    omega_stage #(
      .N_PORTS(N_PORTS),
      .LOG_N  (LOG_N),
      .DATA_W (DATA_W),
      .STAGE  (k)
    ) u_stage (
      .v_i  (v_s[k]),
      .b_i  (b_s[k]),
      .src_i(s_s[k]),
      .dst_i(d_s[k]),
      .dat_i(x_s[k]),
      .v_o  (v_s[k+1]),
      .b_o  (b_s[k+1]),
      .src_o(s_s[k+1]),
      .dst_o(d_s[k+1]),
      .dat_o(x_s[k+1]),
      .blk_o(blk_s[k])
    );
  end

  always_comb begin
    blk_all = ing_blk;
    for (int k = 0; k < LOG_N; k++) blk_all = blk_all | blk_s[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q <= '0;
      out_s_q <= '0;
      out_x_q <= '0;
      blk_q   <= '0;
    end else begin
      out_v_q <= v_s[LOG_N];
      out_s_q <= s_s[LOG_N];
      out_x_q <= x_s[LOG_N];
      blk_q   <= blk_all;
    end
  end

  assign out_valid_o = out_v_q;
  assign out_src_o   = out_s_q;
  assign out_data_o  = out_x_q;
  assign blocked_o   = blk_q;

endmodule

// File: rtl/omega_fabric_chk.sv
module omega_fabric_chk #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 16,
  parameter int LOG_N   = $clog2(N_PORTS)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [N_PORTS-1:0]          in_valid_i,
  input logic [N_PORTS-1:0]          in_bcast_i,
  input logic [N_PORTS*LOG_N-1:0]    in_dest_i,
  input logic [N_PORTS*DATA_W-1:0]   in_data_i,
  input logic [N_PORTS-1:0]          out_valid_o,
  input logic [N_PORTS*LOG_N-1:0]    out_src_o,
  input logic [N_PORTS*DATA_W-1:0]   out_data_o,
  input logic [N_PORTS-1:0]          blocked_o
);

  logic [1:0]         age;
  logic [N_PORTS-1:0] vld_d1, vld_d2, bc_d1, bc_d2;
  logic               ok, legal_bc, any_bc, single;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age    <= '0;
      vld_d1 <= '0;
      vld_d2 <= '0;
      bc_d1  <= '0;
      bc_d2  <= '0;
    end else begin
      if (age != 2'd2) age <= age + 2'd1;
      vld_d1 <= in_valid_i;
      vld_d2 <= vld_d1;
      bc_d1  <= in_bcast_i;
      bc_d2  <= bc_d1;
    end
  end

  assign ok       = (age == 2'd2);
  assign any_bc   = |(vld_d2 & bc_d2);
  assign single   = ($countones(vld_d2) == 1);
  assign legal_bc = single && any_bc;

  a_r2_single_delivered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && single && !any_bc |-> ($countones(out_valid_o) == 1) && (blocked_o == '0));

  a_r3_conserve: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && !legal_bc |->
      ($countones(out_valid_o) + $countones(blocked_o)) == $countones(vld_d2));

  a_r5_bcast_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && legal_bc |-> (out_valid_o == '1) && (blocked_o == '0));

  a_r6_bcast_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && any_bc && !single |-> ((blocked_o & vld_d2 & bc_d2) == (vld_d2 & bc_d2)));

  a_r7_idle_not_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok |-> ((blocked_o & ~vld_d2) == '0));

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok |-> (out_valid_o == '0) && (blocked_o == '0));

endmodule

bind omega_fabric omega_fabric_chk #(
  .N_PORTS(N_PORTS),
  .DATA_W (DATA_W),
  .LOG_N  (LOG_N)
) u_chk (.*);

// File: tb/sim_omega_fabric.sv
module sim_omega_fabric;

  localparam int N  = 8;
  localparam int LG = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]          t_valid, t_bcast;
  logic [N-1:0][LG-1:0]  t_dest;
  logic [N-1:0][DW-1:0]  t_data;
  logic [N-1:0]          o_valid, o_blk;
  logic [N-1:0][LG-1:0]  o_src;
  logic [N-1:0][DW-1:0]  o_data;

  omega_fabric #(.N_PORTS(N), .DATA_W(DW)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (t_valid),
    .in_bcast_i (t_bcast),
    .in_dest_i  (t_dest),
    .in_data_i  (t_data),
    .out_valid_o(o_valid),
    .out_src_o  (o_src),
    .out_data_o (o_data),
    .blocked_o  (o_blk)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // prediction queue, two deep
  logic [N-1:0]         e1_v, e2_v, e1_b, e2_b;
  logic [N-1:0][LG-1:0] e1_s, e2_s;
  logic [N-1:0][DW-1:0] e1_x, e2_x;
  string                e1_t, e2_t;

  task automatic chk(input string req, input string what, input logic [127:0] got, input logic [127:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic model(input logic [N-1:0] v, input logic [N-1:0] b,
                       input logic [N-1:0][LG-1:0] d, input logic [N-1:0][DW-1:0] x,
                       output logic [N-1:0] ov, output logic [N-1:0] ob,
                       output logic [N-1:0][LG-1:0] os, output logic [N-1:0][DW-1:0] ox);
    int pos[N];
    int owner[N];
    logic [N-1:0] alive;
    int cnt;
    ov = '0; ob = '0; os = '0; ox = '0;
    cnt = $countones(v);
    if (cnt == 1 && |(v & b)) begin
      for (int s = 0; s < N; s++) if (v[s]) begin
        for (int j = 0; j < N; j++) begin
          ov[j] = 1'b1; os[j] = LG'(s); ox[j] = x[s];
        end
      end
      return;
    end
    alive = v;
    for (int s = 0; s < N; s++) begin
      pos[s] = s;
      if (v[s] && b[s]) begin ob[s] = 1'b1; alive[s] = 1'b0; end
    end
    for (int k = 0; k < LG; k++) begin
      int rp[N];
      for (int q = 0; q < N; q++) owner[q] = -1;
      for (int s = 0; s < N; s++) begin
        rp[s] = ((pos[s] << 1) | (pos[s] >> (LG - 1))) & (N - 1);
      end
      for (int s = 0; s < N; s++) if (alive[s]) begin
        int want;
        want = (rp[s] & ~1) | int'(d[s][LG-1-k]);
        if (owner[want] < 0) owner[want] = s;
        else if (rp[s] % 2 == 0) begin
          ob[owner[want]] = 1'b1; alive[owner[want]] = 1'b0; owner[want] = s;
        end else begin
          ob[s] = 1'b1; alive[s] = 1'b0;
        end
      end
      for (int s = 0; s < N; s++) if (alive[s]) pos[s] = (rp[s] & ~1) | int'(d[s][LG-1-k]);
    end
    for (int s = 0; s < N; s++) if (alive[s]) begin
      ov[pos[s]] = 1'b1; os[pos[s]] = LG'(s); ox[pos[s]] = x[s];
    end
  endtask

  task automatic compare_now();
    chk(e2_t, "out_valid", 128'(o_valid), 128'(e2_v));
    chk(e2_t, "blocked", 128'(o_blk), 128'(e2_b));
    for (int j = 0; j < N; j++) begin
      if (e2_v[j]) begin
        chk(e2_t, $sformatf("src@%0d", j), 128'(o_src[j]), 128'(e2_s[j]));
        chk(e2_t, $sformatf("data@%0d", j), 128'(o_data[j]), 128'(e2_x[j]));
      end
    end
  endtask

  // called at a falling edge: check, shift queue, drive new vector
  task automatic step(input logic [N-1:0] v, input logic [N-1:0] b,
                      input logic [N-1:0][LG-1:0] d, input logic [N-1:0][DW-1:0] x,
                      input string tag);
    compare_now();
    e2_v = e1_v; e2_b = e1_b; e2_s = e1_s; e2_x = e1_x; e2_t = e1_t;
    model(v, b, d, x, e1_v, e1_b, e1_s, e1_x);
    e1_t = tag;
    t_valid = v; t_bcast = b; t_dest = d; t_data = x;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step('0, '0, '0, '0, tag);
  endtask

  function automatic logic [N-1:0][DW-1:0] pay(input int seed);
    logic [N-1:0][DW-1:0] r;
    for (int s = 0; s < N; s++) r[s] = DW'(seed * 97 + s * 13 + 16'h5a00);
    return r;
  endfunction

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0][LG-1:0] d;
    t_valid = '0; t_bcast = '0; t_dest = '0; t_data = '0;
    e1_v = '0; e2_v = '0; e1_b = '0; e2_b = '0;
    e1_s = '0; e2_s = '0; e1_x = '0; e2_x = '0;
    e1_t = "R1"; e2_t = "R1";
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", 128'(o_valid), 128'(0));
    chk("R1", "blocked in reset", 128'(o_blk), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    idle("R1");
    idle("R1");

    // R2: lone messages, every source
    for (int s = 0; s < N; s++) begin
      d = '0;
      d[s] = LG'((s * 3 + 1) % N);
      step(N'(1) << s, '0, d, pay(s), "R2");
    end
    idle("R7");

    // R4: identity and cyclic shifts, back to back
    for (int sh = 0; sh < N; sh++) begin
      for (int s = 0; s < N; s++) d[s] = LG'((s + sh) % N);
      step('1, '0, d, pay(100 + sh), "R4");
    end

    // R3: two messages meeting at a column-1 element, upper wins
    d = '0; d[0] = 3'd5; d[6] = 3'd4;
    step(8'b0100_0001, '0, d, pay(7), "R3");
    // R3: bit-reversal permutation
    for (int s = 0; s < N; s++) d[s] = {LG'(s)}[0 +: 1] ? LG'({s[0], s[1], s[2]}) : LG'({s[0], s[1], s[2]});
    step('1, '0, d, pay(8), "R3");
    // R3: everyone to one port
    d = '0;
    step('1, '0, d, pay(9), "R3");

    // R5: lone broadcast from every source
    for (int s = 0; s < N; s++) begin
      d = '0; d[s] = LG'(N - 1 - s);
      step(N'(1) << s, N'(1) << s, d, pay(200 + s), "R5");
    end

    // R6: broadcast alongside traffic, and two broadcasts together
    for (int s = 0; s < N; s++) d[s] = LG'(s);
    step(8'b0001_0011, 8'b0000_0010, d, pay(300), "R6");
    step(8'b1000_0100, 8'b1000_0100, d, pay(301), "R6");
    step('1, 8'b0100_0000, d, pay(302), "R6");

    // R7: idle sources alongside busy ones, then fully idle
    step(8'b0010_0000, 8'b1101_1111, d, pay(303), "R7");
    idle("R7");

    // R3: mixed load
    for (int i = 0; i < 300; i++) begin
      logic [N-1:0] v, b;
      v = N'($urandom);
      b = ($urandom % 8 == 0) ? N'($urandom) : '0;
      for (int s = 0; s < N; s++) d[s] = LG'($urandom);
      step(v, b, d, pay(400 + i), "R3");
    end

    idle("R7");
    idle("R7");
    idle("R7");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule